// File: doc/BRIEF.md
# SPI Serial Clock Divider with Edge Strobes

This block turns a fast module clock into the serial clock of an SPI master, and gives the shift engine beside it a pair of one-cycle strobes. One strobe marks the edge where the serial clock leaves its idle level, and the other marks the edge where it returns to it. The division ratio comes from a 13-bit control word that holds two divide fields and one bit that picks between them. In linear mode the serial clock runs at the module clock over 2·(n+1). In exponential mode it runs at the module clock over 2^(n+1).

A `run` input starts and stops the clock. While `run` is low the divider is cleared and the serial clock rests at the idle level set by `cpol`. A new divide value written while the clock runs is taken only at the end of a full period. This keeps the output free of runt pulses and keeps the duty cycle at exactly one half.

Top module: `spi_sclk_divider`

## Requirements
- R1: After a synchronous reset with `run` low and `cpol` low, `sclk`, `lead_stb` and `trail_stb` are all 0.
- R2: When bit 12 of `div_ctrl` is 1 (linear mode), the half period is n+1 module clocks, where n is `div_ctrl[7:0]`. Bits 11:8 have no effect in this mode.
- R3: When bit 12 of `div_ctrl` is 0 (exponential mode), the half period is 2^n module clocks, where n is `div_ctrl[11:8]`. Bits 7:0 have no effect in this mode.
- R4: Let h be the half period. Counting the first rising clock edge at which `run` is sampled high as cycle 1, `sclk` changes at cycles h, 2h, 3h and so on. The changes alternate between leading and trailing, and the first one is leading, which gives a 50% duty cycle.
- R5: `lead_stb` and `trail_stb` are high for exactly the cycle in which `sclk` takes its new value. They are never high together.
- R6: A change to `div_ctrl` while running takes effect only at the next trailing edge. The period in progress finishes at the old half period.
- R7: When `run` is sampled low, `sclk` returns to the idle level one cycle later, no strobe is produced, and the period count restarts. This holds even in the middle of a period.
- R8: The idle level equals `cpol` as sampled while `run` is low. A leading edge drives `sclk` to the opposite of that level, and a trailing edge drives it back to that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables the divider; low holds the idle level |
| cpol | input | 1 | Idle level of the serial clock |
| div_ctrl | input | 13 | [7:0] linear n, [11:8] exponential n, [12] 1 = linear mode |
| sclk | output | 1 | Divided serial clock (registered) |
| lead_stb | output | 1 | One-cycle strobe on the edge leaving idle |
| trail_stb | output | 1 | One-cycle strobe on the edge returning to idle |

## Verification
All outputs are registered, so the first change of `sclk` appears exactly h rising edges after `run` is first sampled high, and each later change follows h edges after the one before. The bench works out each expected strobe as an absolute cycle count from that first edge. It then compares the count at which the strobe is actually seen, sampling on the falling edge. After `run` drops, the idle level is checked one edge later. The control word is always set one cycle before `run` rises, so that the stopped divider has already taken it in.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;
  typedef enum logic {
    DIV_EXP = 1'b0,
    DIV_LIN = 1'b1
  } div_mode_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
  import spi_clkdiv_pkg::*;
#(
  parameter int LIN_W  = 8,
  parameter int EXP_W  = 4,
  parameter int HALF_W = 16,
  localparam int CTRL_W = LIN_W + EXP_W + 1
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [HALF_W-1:0] half_o
);
  localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

  div_mode_e        mode;
  logic [LIN_W-1:0] lin_n;
  logic [EXP_W-1:0] exp_n;

  assign mode  = div_mode_e'(ctrl_i[LIN_W+EXP_W]);
  assign lin_n = ctrl_i[LIN_W-1:0];
  assign exp_n = ctrl_i[LIN_W+EXP_W-1:LIN_W];

  always_comb begin
    if (mode == DIV_LIN) half_o = {{(HALF_W-LIN_W){1'b0}}, lin_n} + ONE;
    else                 half_o = ONE << exp_n;
  end
endmodule

// File: rtl/clkdiv_timer.sv
module clkdiv_timer #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              cpol,
  input  logic [HALF_W-1:0] half_i,
  output logic              tog_o,
  output logic              phase_o,
  output logic              pol_o
);
  localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

  logic [HALF_W-1:0] half_q, cnt_q;
  logic              phase_q, pol_q;

  assign tog_o   = run && (cnt_q == half_q - ONE);
  assign phase_o = phase_q;
  assign pol_o   = pol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      half_q  <= ONE;
      pol_q   <= 1'b0;
    end else if (!run) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      half_q  <= half_i;
      pol_q   <= cpol;
    end else if (tog_o) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
      if (phase_q) half_q <= half_i;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  // R4
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < half_q);

  // R6
  half_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$past(rst) && !($past(tog_o) && $past(phase_q)))
      |-> $stable(half_q));
endmodule

// File: rtl/clkdiv_edges.sv
module clkdiv_edges (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic cpol,
  input  logic tog_i,
  input  logic phase_i,
  input  logic pol_i,
  output logic sclk_o,
  output logic lead_o,
  output logic trail_o
);
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      sclk_o  <= cpol;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else begin
      sclk_o  <= pol_i ^ (phase_i ^ tog_i);
      lead_o  <= tog_i & ~phase_i;
      trail_o <= tog_i & phase_i;
    end
  end

  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(lead_o && trail_o));

  // R5
  lead_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (lead_o || trail_o) |-> (sclk_o != $past(sclk_o)));

  // R8
  lead_level_chk: assert property (@(posedge clk) disable iff (rst)
    lead_o |-> (sclk_o != pol_i));

  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!lead_o && !trail_o && sclk_o == $past(cpol)));
endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider
  import spi_clkdiv_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  localparam int CTRL_W = LIN_W + EXP_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              cpol,
  input  logic [CTRL_W-1:0] div_ctrl,
  output logic              sclk,
  output logic              lead_stb,
  output logic              trail_stb
);
  localparam int HALF_W = max_int(LIN_W + 1, 1 << EXP_W);

  logic [HALF_W-1:0] half;
  logic              tog, phase, pol;

  clkdiv_decode #(.LIN_W(LIN_W), .EXP_W(EXP_W), .HALF_W(HALF_W)) dec_i (
    .ctrl_i (div_ctrl),
    .half_o (half)
  );

  clkdiv_timer #(.HALF_W(HALF_W)) tmr_i (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .cpol    (cpol),
    .half_i  (half),
    .tog_o   (tog),
    .phase_o (phase),
    .pol_o   (pol)
  );

  clkdiv_edges edg_i (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .cpol    (cpol),
    .tog_i   (tog),
    .phase_i (phase),
    .pol_i   (pol),
    .sclk_o  (sclk),
    .lead_o  (lead_stb),
    .trail_o (trail_stb)
  );
endmodule

// File: tb/spi_sclk_divider_tb_top.sv
module spi_sclk_divider_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        cpol = 1'b0;
  logic [12:0] div_ctrl = 13'h1000;
  logic        sclk, lead_stb, trail_stb;

  typedef struct {
    int    at;
    bit    lead;
    string req;
  } ev_t;

  ev_t exp_q[$];
  int  total = 0;
  int  bad = 0;
  int  cyc = 0;
  bit  exp_pol = 1'b0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_sclk_divider dut_i (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .cpol      (cpol),
    .div_ctrl  (div_ctrl),
    .sclk      (sclk),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Expected half period straight from R2/R3 encoding
  function automatic int half_of(input logic [12:0] c);
    if (c[12]) return int'(c[7:0]) + 1;
    return 1 << c[11:8];
  endfunction

  // Monitor: pops expected strobes from the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      cyc = run ? cyc + 1 : 0;
      if (lead_stb || trail_stb) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7", "unexpected strobe at cycle", cyc, -1);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          chk(cyc == e.at, e.req, "strobe cycle", cyc, e.at);
          chk(lead_stb == e.lead && !(lead_stb && trail_stb), "R5",
              "lead strobe kind", int'(lead_stb), int'(e.lead));
          chk(sclk == (e.lead ? !exp_pol : exp_pol), "R8",
              "sclk level at strobe", int'(sclk),
              int'(e.lead ? !exp_pol : exp_pol));
        end
      end
    end
  end

  task automatic start(input logic [12:0] c, input bit pol);
    @(negedge clk); #1;
    div_ctrl = c;
    cpol = pol;
    exp_pol = pol;
    @(negedge clk); #1;
    run = 1'b1;
  endtask

  task automatic stop_check();
    #1 run = 1'b0;
    @(negedge clk);
    chk(sclk == exp_pol, "R7", "idle sclk after stop", int'(sclk), int'(exp_pol));
    chk(exp_q.size() == 0, "R4", "expected strobes missing", exp_q.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  // Driver: push every strobe expected up to the stop cycle, then run
  task automatic run_cfg(input logic [12:0] c, input bit pol, input int stop_at);
    int    h;
    string req;
    h = half_of(c);
    req = c[12] ? "R2" : "R3";
    for (int k = 1; k * h <= stop_at; k++) begin
      ev_t e;
      e.at = k * h;
      e.lead = (k % 2) == 1;
      e.req = req;
      exp_q.push_back(e);
    end
    start(c, pol);
    repeat (stop_at) @(negedge clk);
    stop_check();
  endtask

  // R6: new setting written mid-period applies after the trailing edge
  task automatic run_change(input logic [12:0] a, input logic [12:0] b, input bit pol);
    int ha, hb;
    ev_t e;
    ha = half_of(a);
    hb = half_of(b);
    e.req = "R6";
    e.at = ha;            e.lead = 1'b1; exp_q.push_back(e);
    e.at = 2*ha;          e.lead = 1'b0; exp_q.push_back(e);
    e.at = 2*ha + hb;     e.lead = 1'b1; exp_q.push_back(e);
    e.at = 2*ha + 2*hb;   e.lead = 1'b0; exp_q.push_back(e);
    start(a, pol);
    repeat (ha) @(negedge clk);
    #1 div_ctrl = b;
    repeat (ha + 2*hb) @(negedge clk);
    stop_check();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b0, "R1", "sclk after reset", int'(sclk), 0);
    chk(!lead_stb && !trail_stb, "R1", "strobes after reset",
        int'(lead_stb) + int'(trail_stb), 0);

    run_cfg(13'h1500, 1'b0, 6);    // R2 linear n=0, junk in 11:8, h=1
    run_cfg(13'h1A02, 1'b1, 12);   // R2 R8 linear n=2, h=3, idle high
    run_cfg(13'h00FF, 1'b0, 4);    // R3 exponential n=0, junk in 7:0, h=1
    run_cfg(13'h03AB, 1'b1, 32);   // R3 R8 exponential n=3, h=8
    run_cfg(13'h10FF, 1'b0, 512);  // R2 linear maximum, h=256
    run_cfg(13'h0F00, 1'b0, 65536);// R3 exponential maximum, h=32768
    run_cfg(13'h1004, 1'b0, 7);    // R7 stop mid-period, h=5
    run_cfg(13'h1004, 1'b1, 10);   // R4 restart counts from zero
    run_change(13'h1001, 13'h0233, 1'b0); // R6 h=2 -> h=4
    run_change(13'h0400, 13'h1800, 1'b1); // R6 h=16 -> h=1

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule